// File: doc/BRIEF.md
# SDRAM Read-Latency and Byte-Mask Data Timer

This block sits beside an SDRAM command scheduler and tracks the data side of each command. It watches the read, write and precharge strobes as the scheduler issues them. From the programmed CAS latency and burst length it works out the clock on which each read beat reaches the controller and the clocks on which write data must be on the bus. It also applies the two byte-lane mask requests with the right delay for each direction.

Each read beat carries a valid bit through a short shift register whose tap is chosen by the CAS latency. Beats already in flight are kept when a new read restarts the burst. A precharge stops further beats, so the bus goes quiet exactly CL clocks after it. A bus-turnaround flag covers every clock in which read data is still due, plus one settle clock after the last beat. The scheduler holds off write commands while the flag is high.

Top module: `sdq_datapath_timer`

## Requirements
- R1: With reset held, and on the first clock after it with no command, rd_capture, wr_drive, bus_turn, rd_lane_en and wr_lane_en are all 0.
- R2: The first beat of a read issued on clock t is captured on clock t+3 when cas3=1 and on clock t+2 when cas3=0.
- R3: An uninterrupted read burst gives contiguous capture clocks, with 1, 2, 4 or 8 beats for bl_code 0, 1, 2 or 3.
- R4: A write issued on clock t raises wr_drive on clock t and on the following beats-1 clocks, with the beat count set by bl_code as in R3.
- R5: While wr_drive is high, wr_lane_en is the inverse of dqm_req on the same clock. Bit 1 is the upper byte lane (data bits 15..8) and bit 0 is the lower byte lane (bits 7..0). While wr_drive is low, wr_lane_en is 0.
- R6: A dqm_req bit that is set on clock c clears the same bit of rd_lane_en on clock c+2. Each lane is masked independently. rd_lane_en is 0 on clocks with no capture.
- R7: A precharge on clock t stops the read burst. Beats issued before t are still captured, and nothing is captured from clock t+CL until a new read arrives.
- R8: A read issued while an earlier read is in flight restarts the burst count from the new command, and the earlier beats already issued are still captured.
- R9: A read issued during a write burst ends wr_drive from that clock on.
- R10: bus_turn is high on every clock from the one after a read beat is issued up to the clock after that beat is captured, and low when no read beat is pending.
- R11: A precharge during a write burst ends wr_drive from that clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_rd | input | 1 | Read command issued this clock |
| cmd_wr | input | 1 | Write command issued this clock |
| cmd_pre | input | 1 | Precharge command issued this clock |
| cas3 | input | 1 | CAS latency select: 1 = 3 clocks, 0 = 2 clocks |
| bl_code | input | 2 | Burst length code: beats = 2**bl_code |
| dqm_req | input | 2 | Byte mask request: bit 1 is the upper lane, bit 0 is the lower lane |
| rd_capture | output | 1 | Read data is valid at the controller this clock |
| rd_lane_en | output | 2 | Byte lanes of the current read beat that carry data |
| wr_drive | output | 1 | Controller must drive write data this clock |
| wr_lane_en | output | 2 | Byte lanes of the current write beat that are written |
| bus_turn | output | 1 | Read data still pending or settling; a write must wait |

## Verification
The assertions take three things for granted about the inputs. At most one of the three command strobes is high on any clock. No write arrives while bus_turn is high. cas3 changes only on a clock where no read beat is pending. The stimulus keeps to these rules by design. Every test starts from an idle bus: the latency select is changed only after a sixteen-clock window has drained the pipe. Writes are issued only on idle clocks. The command pattern of each test is laid out as one strobe per clock offset.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

    localparam int CL_SHORT = 2;
    localparam int CL_LONG  = 3;

    typedef struct packed {
        logic rd;
        logic wr;
        logic pre;
    } sdq_cmd_s;

    function automatic int latency_of(input logic long_cl);
        return long_cl ? CL_LONG : CL_SHORT;
    endfunction

    function automatic int unsigned beats_of(input int unsigned code);
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/sdq_burst_gen.sv
module sdq_burst_gen
    import sdq_pkg::*;
#(
    parameter int BL_CODE_W = 2,
    localparam int LEFT_W   = (1 << BL_CODE_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  sdq_cmd_s             cmd,
    input  logic [BL_CODE_W-1:0] bl_code,
    output logic                 rd_issue,
    output logic                 wr_drive
);

    logic [LEFT_W-1:0] rd_left;
    logic [LEFT_W-1:0] wr_left;
    logic [LEFT_W-1:0] span;

    always_comb begin
        span     = LEFT_W'(beats_of(32'(bl_code)) - 32'd1);
        rd_issue = cmd.rd | ((rd_left != '0) && !cmd.wr && !cmd.pre);
        wr_drive = cmd.wr | ((wr_left != '0) && !cmd.rd && !cmd.pre);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_left <= '0;
            wr_left <= '0;
        end else if (cmd.rd) begin
            rd_left <= span;
            wr_left <= '0;
        end else if (cmd.wr) begin
            wr_left <= span;
            rd_left <= '0;
        end else if (cmd.pre) begin
            rd_left <= '0;
            wr_left <= '0;
        end else begin
            if (rd_left != '0) rd_left <= rd_left - 1'b1;
            if (wr_left != '0) wr_left <= wr_left - 1'b1;
        end
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.rd, cmd.wr, cmd.pre})) else $error("commands overlap"); // R9

    AST_ONE_DIR: assert property (@(posedge clk) disable iff (rst)
        !(rd_issue && wr_drive)) else $error("read and write beat together"); // R9

    AST_PRE_HALTS_RD: assert property (@(posedge clk) disable iff (rst)
        cmd.pre |=> (!rd_issue || cmd.rd)) else $error("read beat after precharge"); // R7

    AST_PRE_HALTS_WR: assert property (@(posedge clk) disable iff (rst)
        cmd.pre |=> (!wr_drive || cmd.wr)) else $error("write beat after precharge"); // R11

endmodule

// File: rtl/sdq_rd_pipe.sv
module sdq_rd_pipe
    import sdq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_issue,
    input  logic cas3,
    output logic rd_capture,
    output logic bus_turn
);

    logic [CL_LONG:1] vld;
    logic             last_cap;
    logic             busy;
    int               lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld      <= '0;
            last_cap <= 1'b0;
        end else begin
            vld      <= {vld[CL_LONG-1:1], rd_issue};
            last_cap <= rd_capture;
        end
    end

    always_comb begin
        lat        = latency_of(cas3);
        rd_capture = vld[lat];
        busy       = 1'b0;
        for (int k = 1; k <= CL_LONG; k++) begin
            if (k <= lat) busy = busy | vld[k];
        end
        bus_turn = busy | last_cap;
    end

    AST_RD_LONG_LAT: assert property (@(posedge clk) disable iff (rst)
        (rd_issue && cas3) |-> ##3 rd_capture) else $error("CL3 beat missing"); // R2

    AST_RD_SHORT_LAT: assert property (@(posedge clk) disable iff (rst)
        (rd_issue && !cas3) |-> ##2 rd_capture) else $error("CL2 beat missing"); // R2

    AST_TURN_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        rd_capture |=> bus_turn) else $error("no settle clock"); // R10

    AST_TURN_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
        rd_issue |=> bus_turn) else $error("turnaround late"); // R10

endmodule

// File: rtl/sdq_lane_mask.sv
module sdq_lane_mask #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] dqm_req,
    input  logic             rd_capture,
    input  logic             wr_drive,
    output logic [LANES-1:0] rd_lane_en,
    output logic [LANES-1:0] wr_lane_en
);

    logic [LANES-1:0] mask_d1;
    logic [LANES-1:0] mask_d2;
    logic [1:0]       age;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_d1 <= '0;
            mask_d2 <= '0;
            age     <= '0;
        end else begin
            mask_d1 <= dqm_req;
            mask_d2 <= mask_d1;
            if (age != 2'd2) age <= age + 1'b1;
        end
    end

    always_comb begin
        rd_lane_en = rd_capture ? ~mask_d2 : '0;
        wr_lane_en = wr_drive   ? ~dqm_req : '0;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        AST_RD_LANE_MASK: assert property (@(posedge clk) disable iff (rst)
            (age == 2'd2 && $past(dqm_req[g], 2)) |-> !rd_lane_en[g])
            else $error("read lane not masked"); // R6
        AST_RD_LANE_OPEN: assert property (@(posedge clk) disable iff (rst)
            (age == 2'd2 && rd_capture && !$past(dqm_req[g], 2)) |-> rd_lane_en[g])
            else $error("read lane wrongly masked"); // R6
    end

endmodule

// File: rtl/sdq_datapath_timer.sv
module sdq_datapath_timer
    import sdq_pkg::*;
#(
    parameter int BL_CODE_W = 2,
    parameter int LANES     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_rd,
    input  logic                 cmd_wr,
    input  logic                 cmd_pre,
    input  logic                 cas3,
    input  logic [BL_CODE_W-1:0] bl_code,
    input  logic [LANES-1:0]     dqm_req,
    output logic                 rd_capture,
    output logic [LANES-1:0]     rd_lane_en,
    output logic                 wr_drive,
    output logic [LANES-1:0]     wr_lane_en,
    output logic                 bus_turn
);

    sdq_cmd_s cmd;
    logic     rd_issue;

    assign cmd = '{rd: cmd_rd, wr: cmd_wr, pre: cmd_pre};

    sdq_burst_gen #(.BL_CODE_W(BL_CODE_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .bl_code  (bl_code),
        .rd_issue (rd_issue),
        .wr_drive (wr_drive)
    );

    sdq_rd_pipe u_pipe (
        .clk        (clk),
        .rst        (rst),
        .rd_issue   (rd_issue),
        .cas3       (cas3),
        .rd_capture (rd_capture),
        .bus_turn   (bus_turn)
    );

    sdq_lane_mask #(.LANES(LANES)) u_mask (
        .clk        (clk),
        .rst        (rst),
        .dqm_req    (dqm_req),
        .rd_capture (rd_capture),
        .wr_drive   (wr_drive),
        .rd_lane_en (rd_lane_en),
        .wr_lane_en (wr_lane_en)
    );

    AST_WR_TURN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |-> !bus_turn) else $error("write during turnaround"); // R10

    AST_CL_STEADY: assert property (@(posedge clk) disable iff (rst)
        (cas3 != $past(cas3)) |-> !bus_turn) else $error("latency changed in flight"); // R2

    AST_PRE_CUT_LONG: assert property (@(posedge clk) disable iff (rst)
        (cmd_pre && cas3) |-> ##3 !rd_capture) else $error("CL3 precharge cutoff"); // R7

    AST_PRE_CUT_SHORT: assert property (@(posedge clk) disable iff (rst)
        (cmd_pre && !cas3) |-> ##2 !rd_capture) else $error("CL2 precharge cutoff"); // R7

    AST_WR_START: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (wr_drive || cmd_rd || cmd_pre || bl_code == '0 || $past(bl_code) == '0))
        else $error("write burst stopped early"); // R4

endmodule

// File: tb/sim_sdq_datapath_timer.sv
module sim_sdq_datapath_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_pre = 1'b0, cas3 = 1'b0;
    logic [1:0] bl_code = 2'd0;
    logic [1:0] dqm_req = 2'd0;
    logic       rd_capture, wr_drive, bus_turn;
    logic [1:0] rd_lane_en, wr_lane_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic       s_rd[WIN], s_wr[WIN], s_pre[WIN];
    logic [1:0] s_dqm[WIN];
    logic       r_cap[WIN], r_wd[WIN], r_bt[WIN];
    logic [1:0] r_rl[WIN], r_wl[WIN];

    // entry: {is_write, cas3, bl_code[1:0], first_offset[3:0], beats[3:0]}
    localparam logic [11:0] VEC [8] = '{
        {1'b0, 1'b1, 2'd0, 4'd3, 4'd1},
        {1'b0, 1'b1, 2'd3, 4'd3, 4'd8},
        {1'b0, 1'b0, 2'd1, 4'd2, 4'd2},
        {1'b0, 1'b0, 2'd2, 4'd2, 4'd4},
        {1'b0, 1'b1, 2'd2, 4'd3, 4'd4},
        {1'b1, 1'b0, 2'd0, 4'd0, 4'd1},
        {1'b1, 1'b1, 2'd3, 4'd0, 4'd8},
        {1'b1, 1'b0, 2'd1, 4'd0, 4'd2}
    };

    sdq_datapath_timer u0 (
        .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
        .cas3(cas3), .bl_code(bl_code), .dqm_req(dqm_req),
        .rd_capture(rd_capture), .rd_lane_en(rd_lane_en), .wr_drive(wr_drive),
        .wr_lane_en(wr_lane_en), .bus_turn(bus_turn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_stim();
        for (int i = 0; i < WIN; i++) begin
            s_rd[i] = 1'b0; s_wr[i] = 1'b0; s_pre[i] = 1'b0; s_dqm[i] = 2'd0;
        end
    endtask

    task automatic record();
        for (int i = 0; i < WIN; i++) begin
            cmd_rd = s_rd[i]; cmd_wr = s_wr[i]; cmd_pre = s_pre[i]; dqm_req = s_dqm[i];
            #1;
            r_cap[i] = rd_capture; r_wd[i] = wr_drive; r_bt[i] = bus_turn;
            r_rl[i]  = rd_lane_en; r_wl[i] = wr_lane_en;
            @(negedge clk);
        end
        cmd_rd = 1'b0; cmd_wr = 1'b0; cmd_pre = 1'b0; dqm_req = 2'd0;
    endtask

    function automatic int count_of(input bit use_wr);
        int c = 0;
        for (int i = 0; i < WIN; i++) c += use_wr ? int'(r_wd[i]) : int'(r_cap[i]);
        return c;
    endfunction

    function automatic int first_of(input bit use_wr);
        for (int i = 0; i < WIN; i++) if (use_wr ? r_wd[i] : r_cap[i]) return i;
        return -1;
    endfunction

    function automatic int last_of(input bit use_wr);
        int l = -1;
        for (int i = 0; i < WIN; i++) if (use_wr ? r_wd[i] : r_cap[i]) l = i;
        return l;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_stim();
        repeat (3) @(negedge clk);
        #1;
        // R1: outputs quiet while reset is held
        chk("R1 capture in reset", int'(rd_capture), 0);
        chk("R1 drive in reset", int'(wr_drive), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 capture after reset", int'(rd_capture), 0);
        chk("R1 turn after reset", int'(bus_turn), 0);
        chk("R1 lanes after reset", int'({rd_lane_en, wr_lane_en}), 0);
        @(negedge clk);

        // R2 R3 R4: table of single bursts
        foreach (VEC[v]) begin
            bit is_wr;
            is_wr   = VEC[v][11];
            cas3    = VEC[v][10];
            bl_code = VEC[v][9:8];
            @(negedge clk);
            clear_stim();
            if (is_wr) s_wr[0] = 1'b1; else s_rd[0] = 1'b1;
            record();
            if (is_wr) begin
                chk("R4 write start offset", first_of(1'b1), int'(VEC[v][7:4]));
                chk("R4 write beats", count_of(1'b1), int'(VEC[v][3:0]));
                chk("R4 write contiguous", last_of(1'b1) - first_of(1'b1) + 1, int'(VEC[v][3:0]));
            end else begin
                chk("R2 first capture offset", first_of(1'b0), int'(VEC[v][7:4]));
                chk("R3 read beats", count_of(1'b0), int'(VEC[v][3:0]));
                chk("R3 read contiguous", last_of(1'b0) - first_of(1'b0) + 1, int'(VEC[v][3:0]));
            end
        end

        // R6: read lane masks two clocks after the request
        cas3 = 1'b0; bl_code = 2'd3;
        @(negedge clk);
        clear_stim(); s_rd[0] = 1'b1; s_dqm[1] = 2'b10; s_dqm[3] = 2'b01;
        record();
        chk("R6 upper masked", int'(r_rl[3]), 1);
        chk("R6 both open", int'(r_rl[4]), 3);
        chk("R6 lower masked", int'(r_rl[5]), 2);
        chk("R6 no lanes without capture", int'(r_rl[0]), 0);

        // R5: write masks on the same clock
        bl_code = 2'd2;
        clear_stim(); s_wr[0] = 1'b1; s_dqm[1] = 2'b01;
        record();
        chk("R5 write lanes open", int'(r_wl[0]), 3);
        chk("R5 lower masked same clock", int'(r_wl[1]), 2);
        chk("R5 no lanes after burst", int'(r_wl[4]), 0);

        // R7: precharge cutoff, CL3
        cas3 = 1'b1; bl_code = 2'd3;
        @(negedge clk);
        clear_stim(); s_rd[0] = 1'b1; s_pre[3] = 1'b1;
        record();
        chk("R7 CL3 beats before cutoff", count_of(1'b0), 3);
        chk("R7 CL3 last beat kept", int'(r_cap[5]), 1);
        chk("R7 CL3 quiet at t+CL", int'(r_cap[6]), 0);

        // R7: precharge cutoff, CL2
        cas3 = 1'b0;
        @(negedge clk);
        clear_stim(); s_rd[0] = 1'b1; s_pre[2] = 1'b1;
        record();
        chk("R7 CL2 beats before cutoff", count_of(1'b0), 2);
        chk("R7 CL2 quiet at t+CL", int'(r_cap[4]), 0);

        // R8: read restarts a read in flight
        cas3 = 1'b1; bl_code = 2'd2;
        @(negedge clk);
        clear_stim(); s_rd[0] = 1'b1; s_rd[2] = 1'b1;
        record();
        chk("R8 earlier beat kept", int'(r_cap[3]), 1);
        chk("R8 total beats", count_of(1'b0), 6);
        chk("R8 burst ends", int'(r_cap[9]), 0);

        // R9: read cuts a write burst
        cas3 = 1'b0; bl_code = 2'd3;
        @(negedge clk);
        clear_stim(); s_wr[0] = 1'b1; s_rd[3] = 1'b1;
        record();
        chk("R9 write beats", count_of(1'b1), 3);
        chk("R9 drive off at read", int'(r_wd[3]), 0);
        chk("R9 read lands", int'(r_cap[5]), 1);

        // R11: precharge cuts a write burst
        clear_stim(); s_wr[0] = 1'b1; s_pre[2] = 1'b1;
        record();
        chk("R11 write beats", count_of(1'b1), 2);

        // R10: turnaround window of a single beat
        bl_code = 2'd0;
        clear_stim(); s_rd[0] = 1'b1;
        record();
        chk("R10 idle at issue", int'(r_bt[0]), 0);
        chk("R10 pending", int'(r_bt[1]), 1);
        chk("R10 settle clock", int'(r_bt[3]), 1);
        chk("R10 released", int'(r_bt[4]), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule